// File: doc/BRIEF.md
# Serial CRC-8 Frame Checker

This block verifies frames that a single-wire sensor bus master has read back from a slave device. The caller delivers the frame one bit per accepted transfer, least significant bit of the first byte first. Each accepted bit is folded into an 8-bit shift register built from the polynomial x^8 + x^5 + x^4 + 1. The register starts from all zeros after reset or a synchronous clear. Two frame lengths are supported: a 56-bit device identity and a 64-bit scratchpad image. In both cases, 8 received check bits follow the payload.

Once the payload has gone in, the register holds the computed CRC, and that value is visible on `crc_value`. The 8 received check bits then pass through the same register. A frame that arrived intact leaves the register at zero. The block raises a one-cycle completion pulse together with a pass flag. The result is advisory only: the checker never stalls the bus by itself. After completion it refuses further bits until it is cleared, and a clear restores ready at once.

The bit input is a valid/ready stream. A bit transfers only on a cycle where `in_valid` and `in_ready` are both high and `clr` is low. `in_ready` is high from reset or clear until the final check bit is taken. It stays low from then until the next clear. A caller holding `in_valid` while `in_ready` is low loses nothing: the bit simply waits. There is no other back-pressure source. Bits may arrive with any number of idle cycles between them.

Top module: `crc8_frame_checker`

## Requirements
- R1: After reset, `crc_value` is 0x00, `in_ready` is 1, and `payload_done`, `frame_done` and `crc_ok` are 0.
- R2: Each accepted bit updates the register as follows. The feedback is the bit XOR register bit 0. The register shifts right by one, and the feedback is XORed into bits 7, 3 and 2 (mask 0x8C). From zero, a 1 gives 0x8C, and a following 0 gives 0x46.
- R3: A cycle with `in_valid` low changes neither the register nor the bit count, whatever `in_bit` holds.
- R4: With `frame_sel` = 0 (identity frame), `payload_done` rises in the cycle after the 56th accepted bit, and stays high until clear. `crc_value` then equals the CRC of those 56 bits; for the bytes 02 1C B8 01 00 00 00 this is 0xA2.
- R5: With `frame_sel` = 1 (scratchpad frame), `payload_done` rises in the cycle after the 64th accepted bit, and `crc_value` then equals the CRC of those 64 bits.
- R6: `frame_done` is high for exactly one cycle: the cycle after the bit that completes payload plus 8 check bits is accepted. In that cycle `crc_ok` is 1 exactly when the register is zero, and `crc_ok` holds its value until clear.
- R7: After completion `in_ready` is 0. Bits offered with `in_valid` high are then ignored: `crc_value`, `crc_ok` and `frame_done` do not change.
- R8: `clr` high on a rising edge returns the block to its reset state, even when a valid bit is offered in the same cycle; that bit is not counted.
- R9: `frame_sel` is captured with the first accepted bit of a frame. Later changes do not alter the frame length.
- R10: A frame whose received check byte is wrong completes with `frame_done` high and `crc_ok` 0. A clear then restores `in_ready` to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of register, count and result |
| frame_sel | input | 1 | Frame length: 0 = 56-bit identity, 1 = 64-bit scratchpad |
| in_valid | input | 1 | Bit offered on `in_bit` |
| in_ready | output | 1 | Block can accept a bit |
| in_bit | input | 1 | Serial data, LSB first |
| crc_value | output | 8 | Current CRC register contents |
| payload_done | output | 1 | Payload fully absorbed; `crc_value` is the computed CRC |
| frame_done | output | 1 | One-cycle pulse when the check bits have been absorbed |
| crc_ok | output | 1 | Register returned to zero at completion |

## Verification
Two functions can fall on the same edge: a synchronous clear and the acceptance of a valid data bit. The bench provokes this by asserting `clr` together with `in_valid` partway through a frame. It then checks that the register is zero, that `payload_done` is low and that `in_ready` is high. Next it feeds two fresh bits and compares the register with 0x8C and then 0x46, which shows that the colliding bit was not counted. A second coincidence is also checked: the final check bit and the completion report. The bench samples `frame_done`, `crc_ok` and `crc_value` in the exact cycle after that bit is accepted, and checks one cycle later that the pulse has ended while the pass flag holds.

// File: rtl/crc8_pkg.sv
package crc8_pkg;
  localparam int CRC_W = 8;
  // x^8 + x^5 + x^4 + 1 in right-shifting (reflected) form
  localparam logic [CRC_W-1:0] POLY_REFL = 8'h8C;
  localparam int ID_FRAME_BITS  = 56;
  localparam int PAD_FRAME_BITS = 64;

  typedef enum logic {
    FRAME_ID  = 1'b0,
    FRAME_PAD = 1'b1
  } frame_kind_e;
endpackage

// File: rtl/crc8_lfsr.sv
module crc8_lfsr #(
  parameter int W = crc8_pkg::CRC_W,
  parameter logic [W-1:0] POLY = crc8_pkg::POLY_REFL
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] crc
);
  logic         fb;
  logic [W-1:0] nxt;

  assign fb = din ^ crc[0];

  for (genvar i = 0; i < W; i++) begin : g_tap
    if (i == W - 1) begin : g_top
      assign nxt[i] = POLY[i] & fb;
    end else begin : g_mid
      assign nxt[i] = crc[i+1] ^ (POLY[i] & fb);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        crc <= '0;
    else if (clr)      crc <= '0;
    else if (shift_en) crc <= nxt;
  end

  // R8
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> crc == '0);
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !clr) |=> $stable(crc));
endmodule

// File: rtl/crc8_bit_counter.sv
module crc8_bit_counter #(
  parameter int ID_BITS  = crc8_pkg::ID_FRAME_BITS,
  parameter int PAD_BITS = crc8_pkg::PAD_FRAME_BITS,
  parameter int CHK_BITS = crc8_pkg::CRC_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bit_take,
  input  logic frame_sel,
  output logic payload_done,
  output logic frame_done,
  output logic complete
);
  localparam int MAX_PAY = (ID_BITS > PAD_BITS) ? ID_BITS : PAD_BITS;
  localparam int CNT_W   = $clog2(MAX_PAY + CHK_BITS + 1);

  logic [CNT_W-1:0] cnt;
  logic             sel_q;
  logic             eff_sel;
  logic [CNT_W-1:0] pay_len;
  logic [CNT_W-1:0] tot_len;
  logic [CNT_W-1:0] cnt_nxt;

  // frame length is fixed by the first accepted bit
  assign eff_sel = (cnt == '0) ? frame_sel : sel_q;
  assign pay_len = sel_q   ? CNT_W'(PAD_BITS) : CNT_W'(ID_BITS);
  assign tot_len = eff_sel ? CNT_W'(PAD_BITS + CHK_BITS) : CNT_W'(ID_BITS + CHK_BITS);
  assign cnt_nxt = cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      sel_q      <= 1'b0;
      complete   <= 1'b0;
      frame_done <= 1'b0;
    end else if (clr) begin
      cnt        <= '0;
      sel_q      <= 1'b0;
      complete   <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (bit_take) begin
        cnt   <= cnt_nxt;
        sel_q <= eff_sel;
        if (cnt_nxt == tot_len) begin
          complete   <= 1'b1;
          frame_done <= 1'b1;
        end
      end
    end
  end

  assign payload_done = (cnt != '0) && (cnt >= pay_len);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
  // R6
  done_on_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(complete) |-> frame_done);
  // R4
  payload_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (payload_done && !clr) |=> payload_done);
  // R7
  no_take_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    complete |-> !bit_take);
endmodule

// File: rtl/crc8_frame_checker.sv
module crc8_frame_checker #(
  parameter int W        = crc8_pkg::CRC_W,
  parameter int ID_BITS  = crc8_pkg::ID_FRAME_BITS,
  parameter int PAD_BITS = crc8_pkg::PAD_FRAME_BITS,
  parameter logic [W-1:0] POLY = crc8_pkg::POLY_REFL
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         frame_sel,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         in_bit,
  output logic [W-1:0] crc_value,
  output logic         payload_done,
  output logic         frame_done,
  output logic         crc_ok
);
  logic complete;
  logic bit_take;

  assign in_ready = !complete;
  assign bit_take = in_valid && in_ready && !clr;

  crc8_lfsr #(.W(W), .POLY(POLY)) u_lfsr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .shift_en (bit_take),
    .din      (in_bit),
    .crc      (crc_value)
  );

  crc8_bit_counter #(.ID_BITS(ID_BITS), .PAD_BITS(PAD_BITS), .CHK_BITS(W)) u_cnt (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr          (clr),
    .bit_take     (bit_take),
    .frame_sel    (frame_sel),
    .payload_done (payload_done),
    .frame_done   (frame_done),
    .complete     (complete)
  );

  assign crc_ok = complete && (crc_value == '0);

  // R6
  ok_means_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crc_ok |-> (crc_value == '0 && !in_ready));
  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !clr) |=> ($stable(crc_value) && $stable(crc_ok)));
  // R10
  ready_after_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> in_ready);
endmodule

// File: tb/crc8_frame_checker_test.sv
module crc8_frame_checker_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0;
  logic       frame_sel = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_bit = 1'b0;
  logic       in_ready;
  logic [7:0] crc_value;
  logic       payload_done;
  logic       frame_done;
  logic       crc_ok;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  crc8_frame_checker uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .frame_sel(frame_sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit),
    .crc_value(crc_value), .payload_done(payload_done),
    .frame_done(frame_done), .crc_ok(crc_ok)
  );

  // {frame_sel, payload[63:0], corrupt_check_byte}
  localparam logic [65:0] VECS [6] = '{
    {1'b0, 64'h0000_0000_01B8_1C02, 1'b0},
    {1'b1, 64'h1234_5678_9ABC_DEF0, 1'b0},
    {1'b0, 64'h00A5_5A3C_C30F_F0E1, 1'b1},
    {1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0},
    {1'b1, 64'h8000_0000_0000_0001, 1'b1},
    {1'b0, 64'h0000_0000_0000_0000, 1'b0}
  };

  function automatic logic [7:0] crc_ref(input logic [63:0] d, input int n);
    logic [7:0] r = 8'h00;
    for (int k = 0; k < n; k++) begin
      logic f = d[k] ^ r[0];
      r = {1'b0, r[7:1]};
      if (f) r = r ^ 8'h8C;
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic b);
    in_valid = 1'b1;
    in_bit   = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n, input logic b);
    in_valid = 1'b0;
    for (int k = 0; k < n; k++) begin
      in_bit = b ^ k[0];
      @(negedge clk);
    end
  endtask

  task automatic clear_blk();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 crc", crc_value, 8'h00);
    chk("R1 ready", {7'd0, in_ready}, 8'd1);
    chk("R1 flags", {5'd0, payload_done, frame_done, crc_ok}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 6; v++) begin
      logic        sel  = VECS[v][65];
      logic [63:0] pay  = VECS[v][64:1];
      logic        bad  = VECS[v][0];
      int          plen = sel ? 64 : 56;
      logic [7:0]  exp  = crc_ref(pay, plen);
      logic [7:0]  rcv  = exp ^ (bad ? 8'h10 : 8'h00);
      clear_blk();
      frame_sel = sel;
      for (int i = 0; i < plen; i++) begin
        if (i % 7 == 3) begin
          idle(2, ~pay[i]);
          // R3 gap bits leave no trace
          if (i == 3) chk("R3 idle", crc_value, crc_ref(pay, 3));
        end
        push(pay[i]);
        if (i == plen - 2) chk(sel ? "R5 early" : "R4 early", {7'd0, payload_done}, 8'd0);
      end
      chk(sel ? "R5 pdone" : "R4 pdone", {7'd0, payload_done}, 8'd1);
      chk(sel ? "R5 crc" : "R4 crc", crc_value, exp);
      if (v == 0) chk("R4 known", crc_value, 8'hA2);
      for (int i = 0; i < 8; i++) push(rcv[i]);
      chk("R6 done", {7'd0, frame_done}, 8'd1);
      chk(bad ? "R10 ok" : "R6 ok", {7'd0, crc_ok}, bad ? 8'd0 : 8'd1);
      if (!bad) chk("R6 zero", crc_value, 8'h00);
      idle(1, 1'b1);
      chk("R6 pulse", {7'd0, frame_done}, 8'd0);
      chk("R6 hold", {7'd0, crc_ok}, bad ? 8'd0 : 8'd1);
      if (v == 0) begin
        // R7 offered bits after completion are ignored
        chk("R7 ready", {7'd0, in_ready}, 8'd0);
        push(1'b1); push(1'b0); push(1'b1);
        chk("R7 crc", crc_value, 8'h00);
        chk("R7 flags", {6'd0, frame_done, crc_ok}, 8'd1);
      end
      if (bad) begin
        clear_blk();
        chk("R10 ready", {7'd0, in_ready}, 8'd1);
      end
    end

    // R8 clear colliding with a valid bit
    clear_blk();
    frame_sel = 1'b0;
    for (int i = 0; i < 10; i++) push(i[0]);
    clr = 1'b1; in_valid = 1'b1; in_bit = 1'b1;
    @(negedge clk);
    clr = 1'b0; in_valid = 1'b0;
    chk("R8 crc", crc_value, 8'h00);
    chk("R8 state", {6'd0, payload_done, in_ready}, 8'd1);
    // R2 single-step values
    push(1'b1);
    chk("R2 step1", crc_value, 8'h8C);
    push(1'b0);
    chk("R2 step2", crc_value, 8'h46);

    // R9 frame length latched at first bit
    begin
      logic [63:0] p = 64'h0F1E_2D3C_4B5A_6978;
      clear_blk();
      frame_sel = 1'b0;
      push(p[0]);
      frame_sel = 1'b1;
      for (int i = 1; i < 56; i++) push(p[i]);
      chk("R9 pdone", {7'd0, payload_done}, 8'd1);
      chk("R9 crc", crc_value, crc_ref(p, 56));
    end

    summary();
  end
endmodule